// File: doc/BRIEF.md
# Programmable parallel I/O controller

This block controls up to 32 chip pins from a simple register bus. Each pin is either driven by the controller's own output registers or handed to an on-chip peripheral, which then supplies the pad value and its output enable. Every control setting is kept in a status bit that software changes through a pair of write-only ports. A 1 in the set port sets the bit. A 1 in the clear port clears it. A 0 in either port has no effect. Six groups use this scheme: pin ownership, output enable, output data, open-drain mode, input filtering and interrupt mask.

On the input side, each pad goes through a two-flop synchronizer. A per-pin glitch filter can then be switched in, and it passes a new level only after the level has held for `FLT_LEN` cycles. The chosen input feeds the pin-data register and the peripheral input. It also feeds change detection, which latches events into an interrupt status register that is cleared when read. The events are masked and ORed onto one interrupt line.

Top module: `pio_ctrl`

## Requirements
- R1: Set/clear semantics. The register groups sit at these word addresses, each as set = base, clear = base+1, status = base+2: pin ownership base 0, output enable base 3, output data base 6, open drain base 9, input filter base 12, interrupt mask base 15. Writing 1 to a bit of a set address sets the status bit, and writing 1 to a bit of a clear address clears it. A 0 bit in either write leaves the status bit unchanged.
- R2: After reset, the ownership status equals `PCTL_RST` (default all ones, controller owns) and the filter status equals `FLT_RST` (default all zero). Output enable, output data, open drain, mask and interrupt status read 0, and the pads are not driven.
- R3: A pin with ownership bit 1 takes its pad value and output enable from the output-data and output-enable status. A pin with ownership bit 0 takes them from `periph_out` and `periph_oe`. Output-enable writes made while a peripheral owns the pin are stored but do not reach the pad until ownership returns to the controller.
- R4: For a pin with its open-drain bit set, `pad_oe` is 1 only when the selected output value is 0 and the selected output enable is 1. In that case `pad_out` is 0. Otherwise the pin is released.
- R5: With the filter off, the pin-data register (address 18) shows a pad input level after two rising clock edges.
- R6: With the filter on, a level must hold for `FLT_LEN` (default 2) consecutive synchronized samples before it reaches pin data. A one-cycle pulse never appears there. This applies whether or not the controller owns the pin.
- R7: Any change of the selected input sets that pin's bit in the interrupt status register (address 19) on the next clock edge. The bit stays set until it is read.
- R8: `irq` is high exactly when some interrupt status bit and the same mask status bit are both 1.
- R9: A read of address 19 returns the current interrupt status and clears it. An event latched on the same edge as the read is kept.
- R10: Reads of write-only addresses (set and clear ports) and of unmapped addresses return 0.
- R11: `periph_in` carries the same selected (synchronized, optionally filtered) input that pin data shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data, combinational |
| pad_in | input | NPINS | Pad input levels, asynchronous |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| periph_out | input | NPINS | Peripheral output value per pin |
| periph_oe | input | NPINS | Peripheral output enable per pin |
| periph_in | output | NPINS | Selected input delivered to the peripheral |
| irq | output | 1 | Masked change interrupt |

## Verification
A stuck or wrongly updated status bit shows up on `pad_out` or `pad_oe` in the cycle after the write. It also shows up as a wrong value the next time its status address is read. A bad synchronizer or filter count moves the cycle in which pin data changes, so the bench reads pin data exactly one cycle before and one cycle after the expected change. A lost or extra event is caught at `irq` and on the next interrupt status read. That read also proves whether the clear-on-read kept an event that arrived on the same edge.

// File: rtl/pio_ctrl.sv
module pio_ctrl #(
  parameter int NPINS = 32,
  parameter int FLT_LEN = 2,
  parameter logic [NPINS-1:0] PCTL_RST = '1,
  parameter logic [NPINS-1:0] FLT_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [4:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  input  logic [NPINS-1:0] periph_out,
  input  logic [NPINS-1:0] periph_oe,
  output logic [NPINS-1:0] periph_in,
  output logic             irq
);
  localparam int CW = $clog2(FLT_LEN) + 1;
  localparam logic [4:0] A_PCTL = 5'd0;
  localparam logic [4:0] A_OE   = 5'd3;
  localparam logic [4:0] A_DOUT = 5'd6;
  localparam logic [4:0] A_ODRN = 5'd9;
  localparam logic [4:0] A_FLT  = 5'd12;
  localparam logic [4:0] A_MASK = 5'd15;
  localparam logic [4:0] A_PIN  = 5'd18;
  localparam logic [4:0] A_ISR  = 5'd19;

  logic [NPINS-1:0] pctl_q, oe_q, dout_q, odrn_q, flt_q, mask_q, isr_q;
  logic [NPINS-1:0] s1_q, s2_q, filt_w, prev_q, sel_in, evt;
  logic [NPINS-1:0] own_o, own_oe;
  logic [NPINS-1:0] wd;
  logic             isr_rd;

  assign wd     = bus_wdata[NPINS-1:0];
  assign isr_rd = bus_rd && (bus_addr == A_ISR);

  function automatic logic [NPINS-1:0] upd(input logic [NPINS-1:0] cur,
                                           input logic [4:0] base,
                                           input logic wr,
                                           input logic [4:0] addr,
                                           input logic [NPINS-1:0] d);
    logic [NPINS-1:0] s, c;
    s = (wr && addr == base) ? d : '0;
    c = (wr && addr == base + 5'd1) ? d : '0;
    return (cur | s) & ~c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pctl_q <= PCTL_RST;
      oe_q   <= '0;
      dout_q <= '0;
      odrn_q <= '0;
      flt_q  <= FLT_RST;
      mask_q <= '0;
    end else begin
      pctl_q <= upd(pctl_q, A_PCTL, bus_wr, bus_addr, wd);
      oe_q   <= upd(oe_q,   A_OE,   bus_wr, bus_addr, wd);
      dout_q <= upd(dout_q, A_DOUT, bus_wr, bus_addr, wd);
      odrn_q <= upd(odrn_q, A_ODRN, bus_wr, bus_addr, wd);
      flt_q  <= upd(flt_q,  A_FLT,  bus_wr, bus_addr, wd);
      mask_q <= upd(mask_q, A_MASK, bus_wr, bus_addr, wd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pad_in;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_flt
    logic [CW-1:0] cnt;
    logic          lvl;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        lvl <= 1'b0;
      end else if (s2_q[i] != lvl) begin
        if (cnt == CW'(FLT_LEN - 1)) begin
          lvl <= s2_q[i];
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
    assign filt_w[i] = lvl;
  end

  assign sel_in    = (flt_q & filt_w) | (~flt_q & s2_q);
  assign evt       = sel_in ^ prev_q;
  assign periph_in = sel_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      isr_q  <= '0;
    end else begin
      prev_q <= sel_in;
      isr_q  <= isr_rd ? evt : (isr_q | evt);
    end
  end

  assign irq = |(isr_q & mask_q);

  assign own_o   = (pctl_q & dout_q) | (~pctl_q & periph_out);
  assign own_oe  = (pctl_q & oe_q)   | (~pctl_q & periph_oe);
  assign pad_oe  = own_oe & ~(odrn_q & own_o);
  assign pad_out = own_o & ~odrn_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_PCTL + 5'd2: bus_rdata = 32'(pctl_q);
        A_OE   + 5'd2: bus_rdata = 32'(oe_q);
        A_DOUT + 5'd2: bus_rdata = 32'(dout_q);
        A_ODRN + 5'd2: bus_rdata = 32'(odrn_q);
        A_FLT  + 5'd2: bus_rdata = 32'(flt_q);
        A_MASK + 5'd2: bus_rdata = 32'(mask_q);
        A_PIN:         bus_rdata = 32'(sel_in);
        A_ISR:         bus_rdata = 32'(isr_q);
        default:       bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [4:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] periph_out,
  input logic [NPINS-1:0] pctl_q,
  input logic [NPINS-1:0] odrn_q,
  input logic [NPINS-1:0] dout_q,
  input logic [NPINS-1:0] oe_q,
  input logic [NPINS-1:0] isr_q,
  input logic [NPINS-1:0] evt
);
  a_r1_oe_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 5'd3) |=>
      ((oe_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

  a_r3_periph_value: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ periph_out) & ~pctl_q & ~odrn_q) == '0);

  a_r4_od_no_high_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & odrn_q & pctl_q & dout_q) == '0);

  a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == 5'd19) |=> (($past(isr_q) & ~isr_q) == '0));

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 5'd19) |=> ((isr_q & ~$past(evt)) == '0));
endmodule

bind pio_ctrl pio_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .periph_out(periph_out), .pctl_q(pctl_q),
  .odrn_q(odrn_q), .dout_q(dout_q), .oe_q(oe_q), .isr_q(isr_q), .evt(evt)
);

// File: tb/test_pio_ctrl.sv
module test_pio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0, pad_out, pad_oe;
  logic [31:0] periph_out = '0, periph_oe = '0, periph_in;
  logic        irq;
  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] e;
  string       t;

  always #4 clk = ~clk;

  pio_ctrl i_pio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .periph_out(periph_out), .periph_oe(periph_oe), .periph_in(periph_in),
    .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  always @(negedge clk) begin
    #2;
    if (bus_rd) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: read with no expected item, actual %h expected none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    rd(5'd2,  32'hFFFF_FFFF, "R2 ownership reset");
    rd(5'd5,  32'h0, "R2 oe reset");
    rd(5'd8,  32'h0, "R2 dout reset");
    rd(5'd11, 32'h0, "R2 odrn reset");
    rd(5'd14, 32'h0, "R2 filter reset");
    rd(5'd17, 32'h0, "R2 mask reset");
    rd(5'd19, 32'h0, "R2 isr reset");
    check("R2 pad_oe reset", pad_oe, 32'h0);
    // R1 set/clear
    wr(5'd3, 32'h0000_00F0);
    rd(5'd5, 32'h0000_00F0, "R1 oe set");
    wr(5'd3, 32'h0000_000F);
    wr(5'd4, 32'h0000_0030);
    rd(5'd5, 32'h0000_00CF, "R1 oe set/clear zeros no effect");
    wr(5'd6, 32'h0000_00FF);
    rd(5'd8, 32'h0000_00FF, "R1 dout set");
    check("R3 pad_out controller", pad_out, 32'h0000_00FF);
    check("R3 pad_oe controller", pad_oe, 32'h0000_00CF);
    // R3 peripheral ownership
    periph_out = 32'h1234_0000; periph_oe = 32'hFFFF_0000;
    wr(5'd1, 32'hFFFF_0000);
    rd(5'd2, 32'h0000_FFFF, "R1 ownership clear");
    check("R3 pad_out mixed", pad_out, 32'h1234_00FF);
    check("R3 pad_oe mixed", pad_oe, 32'hFFFF_00CF);
    wr(5'd3, 32'h0001_0000);
    rd(5'd5, 32'h0001_00CF, "R3 oe stored while peripheral owns");
    check("R3 stored oe not at pad", pad_oe, 32'hFFFF_00CF);
    periph_oe = 32'h0;
    #1 check("R3 periph_oe follows", pad_oe, 32'h0000_00CF);
    wr(5'd0, 32'h0001_0000);
    check("R3 stored oe reaches pad", pad_oe, 32'h0001_00CF);
    check("R3 pad_out after return", pad_out, 32'h1234_00FF);
    // R4 open drain
    wr(5'd9, 32'h3);
    rd(5'd11, 32'h3, "R1 odrn set");
    check("R4 od released high", pad_oe, 32'h0001_00CC);
    check("R4 od pad_out", pad_out, 32'h1234_00FC);
    wr(5'd7, 32'h1);
    check("R4 od drives low", pad_oe, 32'h0001_00CD);
    check("R4 od pad_out low", pad_out, 32'h1234_00FC);
    // R5 R7 R8
    wr(5'd15, 32'h1);
    rd(5'd17, 32'h1, "R1 mask set");
    @(negedge clk); pad_in[0] = 1'b1;
    rd(5'd18, 32'h0, "R5 pin data one edge");
    check("R7 irq not yet", {31'b0, irq}, 32'h0);
    rd(5'd18, 32'h1, "R5 pin data two edges");
    check("R8 irq masked event", {31'b0, irq}, 32'h1);
    rd(5'd19, 32'h1, "R7 isr event");
    check("R9 irq after clear", {31'b0, irq}, 32'h0);
    // R9 event on read edge kept
    @(negedge clk); pad_in[1] = 1'b1;
    @(negedge clk);
    rd(5'd19, 32'h0, "R9 read during event");
    check("R8 unmasked event no irq", {31'b0, irq}, 32'h0);
    rd(5'd19, 32'h2, "R9 event kept");
    // R10
    rd(5'd0,  32'h0, "R10 write-only set");
    rd(5'd4,  32'h0, "R10 write-only clear");
    rd(5'd25, 32'h0, "R10 unmapped");
    // R6 filter
    wr(5'd12, 32'h0010_0004);
    rd(5'd14, 32'h0010_0004, "R1 filter set");
    @(negedge clk); pad_in[2] = 1'b1; pad_in[3] = 1'b1;
    @(negedge clk); pad_in[2] = 1'b0; pad_in[3] = 1'b0;
    repeat (6) @(negedge clk);
    rd(5'd18, 32'h3, "R6 pulse rejected");
    rd(5'd19, 32'h8, "R7 unfiltered pulse event");
    @(negedge clk); pad_in[2] = 1'b1; pad_in[20] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(5'd18, 32'h3, "R6 not yet passed");
    rd(5'd18, 32'h0010_0007, "R6 level passed");
    check("R11 periph_in", periph_in, 32'h0010_0007);
    check("R8 irq unmasked filter events", {31'b0, irq}, 32'h0);
    rd(5'd19, 32'h0010_0004, "R7 filtered events");
    wr(5'd13, 32'h0010_0004);
    rd(5'd14, 32'h0, "R1 filter clear");
    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule